// File: doc/BRIEF.md
# One-of-four serial word link

This block moves 32-bit words across a long on-chip route using only five wires: four data lines that carry one-hot codes and one acknowledge line that runs back from the receiver. The transmitter accepts a word on a valid/ready input and splits it into sixteen 2-bit symbols. Each symbol raises exactly one of the four data lines. The transmitter holds that code until the receiver acknowledges it, then returns all four lines to zero and waits for the acknowledge to drop before it sends the next symbol. No clock or strobe paces the route. The receiver sees a new symbol arrive when one data line goes high, and it sees the gap between symbols when all four are low. The link therefore keeps working whatever the delay on each wire.

Both ends are modelled in a single clock domain. Every wire that crosses the link passes through a two-flop synchronizer on the side that samples it. The data lines and the acknowledge are separate ports, so the integrator, or a bench, can route them with any delay or insert faults. The receiver rebuilds the word and presents it on a valid/ready output. It stalls the link, by withholding its acknowledge, while a finished word is still unread. If more than one data line is high at once, the receiver raises a sticky error.

Top module: `q4_link`

## Requirements
- R1: After reset, `line_o` is 0000, `ack_o` is low, `in_ready` is high, `out_valid` is low and `err` is low.
- R2: While a symbol is on the lines, exactly one bit of `line_o` is high. Symbol value v (0 to 3) drives bit v, so 00 gives 0001, 01 gives 0010, 10 gives 0100 and 11 gives 1000.
- R3: A word goes out as 16 consecutive symbols. The first symbol is bits [1:0], the next is bits [3:2], and so on up to bits [31:30].
- R4: The transmitter returns `line_o` to 0000 only after it has seen the acknowledge high. It drives the next code only after it has seen the acknowledge low again.
- R5: The receiver raises `ack_o` only after it sees a valid one-hot code. It lowers `ack_o` only after it sees all four lines at zero.
- R6: After all 16 symbols arrive, `out_data` equals the word that was sent and `out_valid` is high.
- R7: `in_ready` stays low from the cycle a word is accepted until the last of its 16 symbols has completed its four-phase handshake.
- R8: Once `out_valid` is high, it stays high and `out_data` stays stable until a cycle in which `out_ready` is high.
- R9: While `out_valid` is high, the receiver does not acknowledge a new symbol. The next word's first code therefore stays on the lines unacknowledged.
- R10: A code with more than one line high sets `err`, which stays set until reset. Such a code is not acknowledged and is not captured into the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ends |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 32 | Word to send |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Transmitter can take a word |
| line_o | output | 4 | Transmit-side one-hot data lines |
| ack_i | input | 1 | Acknowledge arriving at the transmitter |
| line_i | input | 4 | Data lines arriving at the receiver |
| ack_o | output | 1 | Acknowledge leaving the receiver |
| out_data | output | 32 | Rebuilt word |
| out_valid | output | 1 | `out_data` holds a complete word |
| out_ready | input | 1 | Consumer takes the word |
| err | output | 1 | Sticky flag for a multi-hot code |

## Verification
The bench uses words whose sixteen pairs cover every symbol value, in both ascending and descending order, as well as all-zero, all-one and edge-bit patterns. A wrong wire mapping or a reversed pair order would show up both in the logged codes and in the rebuilt word. A wire monitor flags any code that is removed before the acknowledge, or driven while the acknowledge is still high. Such a fault would let a symbol be lost or counted twice. In the backpressure case, a second word is sent while the first is still unread. A receiver that acknowledged anyway would overwrite the first word, and a transmitter that took words early would raise `in_ready`. A multi-hot code is injected between words. A receiver that decoded it would shift a wrong pair into the next word, and a non-sticky flag would clear once the fault was removed.

// File: rtl/q4_link_pkg.sv
package q4_link_pkg;

    localparam int SYM_BITS = 2;
    localparam int LINES    = 4;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_CODE,
        TX_RTZ
    } tx_state_e;

    typedef enum logic {
        RX_WAIT_CODE,
        RX_WAIT_ZERO
    } rx_state_e;

    function automatic logic [LINES-1:0] sym_to_lines(input logic [SYM_BITS-1:0] s);
        return LINES'(1) << s;
    endfunction

    function automatic logic [SYM_BITS-1:0] lines_to_sym(input logic [LINES-1:0] w);
        logic [SYM_BITS-1:0] s;
        s = '0;
        for (int i = 0; i < LINES; i++) begin
            if (w[i]) s = SYM_BITS'(i);
        end
        return s;
    endfunction

    function automatic logic lines_one_hot(input logic [LINES-1:0] w);
        return (w != '0) && ((w & (w - LINES'(1))) == '0);
    endfunction

    function automatic logic lines_multi_hot(input logic [LINES-1:0] w);
        return (w & (w - LINES'(1))) != '0;
    endfunction

endpackage

// File: rtl/q4_sync.sv
module q4_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= '0;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/q4_tx.sv
module q4_tx
    import q4_link_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              ack_s,
    output logic [LINES-1:0]  line_o
);
    localparam int NSYM  = WORD_W / SYM_BITS;
    localparam int CNT_W = $clog2(NSYM);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NSYM - 1);

    tx_state_e         st;
    logic [WORD_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic [LINES-1:0]  line_q;

    assign in_ready = (st == TX_IDLE);
    assign line_o   = line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= TX_IDLE;
            sh     <= '0;
            cnt    <= '0;
            line_q <= '0;
        end else begin
            unique case (st)
                TX_IDLE: if (in_valid) begin
                    sh     <= in_data;
                    cnt    <= '0;
                    line_q <= sym_to_lines(in_data[SYM_BITS-1:0]);
                    st     <= TX_CODE;
                end
                TX_CODE: if (ack_s) begin
                    line_q <= '0;
                    st     <= TX_RTZ;
                end
                TX_RTZ: if (!ack_s) begin
                    if (cnt == LAST) begin
                        st <= TX_IDLE;
                    end else begin
                        sh     <= sh >> SYM_BITS;
                        cnt    <= cnt + CNT_W'(1);
                        line_q <= sym_to_lines(sh[2*SYM_BITS-1:SYM_BITS]);
                        st     <= TX_CODE;
                    end
                end
                default: st <= TX_IDLE;
            endcase
        end
    end

    assert_code_one_hot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(line_q));

    assert_zero_after_ack_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(line_q) != '0 && line_q == '0) |-> $past(ack_s));

    assert_code_after_release_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(line_q) == '0 && line_q != '0) |-> !$past(ack_s));

    assert_idle_lines_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (line_q == '0));
endmodule

// File: rtl/q4_rx.sv
module q4_rx
    import q4_link_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINES-1:0]  line_s,
    output logic              ack_o,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              err
);
    localparam int NSYM  = WORD_W / SYM_BITS;
    localparam int CNT_W = $clog2(NSYM);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NSYM - 1);

    rx_state_e         st;
    logic [WORD_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              ack_q;
    logic              valid_q;
    logic              err_q;

    assign ack_o     = ack_q;
    assign out_data  = sh;
    assign out_valid = valid_q;
    assign err       = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= RX_WAIT_CODE;
            sh      <= '0;
            cnt     <= '0;
            ack_q   <= 1'b0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (valid_q && out_ready) valid_q <= 1'b0;
            if (lines_multi_hot(line_s)) err_q <= 1'b1;
            unique case (st)
                RX_WAIT_CODE: if (lines_one_hot(line_s) && !valid_q) begin
                    sh    <= {lines_to_sym(line_s), sh[WORD_W-1:SYM_BITS]};
                    ack_q <= 1'b1;
                    st    <= RX_WAIT_ZERO;
                    if (cnt == LAST) begin
                        cnt     <= '0;
                        valid_q <= 1'b1;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                RX_WAIT_ZERO: if (line_s == '0) begin
                    ack_q <= 1'b0;
                    st    <= RX_WAIT_CODE;
                end
                default: st <= RX_WAIT_CODE;
            endcase
        end
    end

    assert_ack_on_code_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_q) |-> ($countones($past(line_s)) == 1));

    assert_release_on_zero_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_q) |-> ($past(line_s) == '0));

    assert_hold_word_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(valid_q) && !$past(out_ready)) |-> (valid_q && $stable(sh)));

    assert_no_ack_unread_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_q) |-> !$past(valid_q));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        $past(err_q) |-> err_q);
endmodule

// File: rtl/q4_link.sv
module q4_link
    import q4_link_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [3:0]        line_o,
    input  logic              ack_i,
    input  logic [3:0]        line_i,
    output logic              ack_o,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              err
);
    logic             ack_s;
    logic [LINES-1:0] line_s;

    q4_sync #(.W(1), .STAGES(SYNC_DEPTH)) u_ack_sync (
        .clk(clk), .rst(rst), .d(ack_i), .q(ack_s)
    );

    q4_sync #(.W(LINES), .STAGES(SYNC_DEPTH)) u_line_sync (
        .clk(clk), .rst(rst), .d(line_i), .q(line_s)
    );

    q4_tx #(.WORD_W(WORD_W)) u_tx (
        .clk(clk), .rst(rst),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .ack_s(ack_s), .line_o(line_o)
    );

    q4_rx #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst(rst),
        .line_s(line_s), .ack_o(ack_o),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .err(err)
    );
endmodule

// File: tb/q4_link_tb_top.sv
`timescale 1ns/1ps
module q4_link_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  line_o;
    logic        ack_o;
    logic [31:0] out_data;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        err;
    logic        inj_en = 1'b0;
    logic [3:0]  inj_val = '0;
    logic [3:0]  line_i;

    always #2 clk = ~clk;

    assign line_i = inj_en ? inj_val : line_o;

    q4_link dut_i (
        .clk(clk), .rst(rst),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .line_o(line_o), .ack_i(ack_o), .line_i(line_i), .ack_o(ack_o),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .err(err)
    );

    localparam logic [31:0] VEC [8] = '{
        32'h0000_0000, 32'hFFFF_FFFF, 32'h1B1B_1B1B, 32'hE4E4_E4E4,
        32'hA5A5_5A5A, 32'h1234_5678, 32'h8000_0001, 32'hDEAD_BEEF
    };

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [3:0] sym_log [256];
    int         sym_total = 0;
    int         hs_viol = 0;
    int         hot_viol = 0;
    logic [3:0] prev_line = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_line == '0 && line_o != '0) begin
                sym_log[sym_total % 256] = line_o;
                sym_total = sym_total + 1;
                if (ack_o) hs_viol = hs_viol + 1;
            end
            if (prev_line != '0 && line_o == '0 && !ack_o) hs_viol = hs_viol + 1;
            if (line_o != '0 && $countones(line_o) != 1) hot_viol = hot_viol + 1;
        end
        prev_line = line_o;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        @(negedge clk);
        check(in_ready == 1'b1, "R7 ready before send", 32'(in_ready), 32'd1);
        in_data  = w;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_valid(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (out_valid) begin ok = 1'b1; break; end
        end
    endtask

    task automatic wait_ready(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (in_ready) begin ok = 1'b1; break; end
        end
    endtask

    task automatic take_word;
        @(negedge clk);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit ok;
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(line_o == 4'b0000, "R1 line_o", 32'(line_o), 32'd0);
        check(ack_o == 1'b0, "R1 ack_o", 32'(ack_o), 32'd0);
        check(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'd1);
        check(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
        check(err == 1'b0, "R1 err", 32'(err), 32'd0);

        // Vector table: each word checked for data, symbol codes and order
        for (int v = 0; v < 8; v++) begin
            base = sym_total;
            send_word(VEC[v]);
            @(negedge clk);
            check(in_ready == 1'b0, "R7 busy after accept", 32'(in_ready), 32'd0);
            wait_valid(ok);
            check(ok, "R6 word delivered", 32'(ok), 32'd1);
            check(out_data == VEC[v], "R6 out_data", out_data, VEC[v]);
            wait_ready(ok);
            check(ok, "R7 ready after 16 symbols", 32'(ok), 32'd1);
            check(sym_total - base == 16, "R3 symbol count", 32'(sym_total - base), 32'd16);
            for (int k = 0; k < 16; k++) begin
                logic [3:0] exp_code;
                exp_code = 4'b0001 << ((VEC[v] >> (2 * k)) & 32'd3);
                check(sym_log[(base + k) % 256] == exp_code, "R2 R3 symbol code",
                      32'(sym_log[(base + k) % 256]), 32'(exp_code));
            end
            check(out_valid == 1'b1, "R8 held until taken", 32'(out_valid), 32'd1);
            take_word();
            check(out_valid == 1'b0, "R8 cleared after take", 32'(out_valid), 32'd0);
        end

        // Backpressure: second word stalls while the first is unread
        send_word(32'hCAFE_0123);
        wait_valid(ok);
        check(ok, "R6 first word", 32'(ok), 32'd1);
        wait_ready(ok);
        base = sym_total;
        send_word(32'h0F0F_3C3C);
        repeat (300) @(negedge clk);
        check(out_valid == 1'b1, "R8 still valid", 32'(out_valid), 32'd1);
        check(out_data == 32'hCAFE_0123, "R8 data stable", out_data, 32'hCAFE_0123);
        check(ack_o == 1'b0, "R9 no ack while unread", 32'(ack_o), 32'd0);
        check(line_o == 4'b0001, "R9 first code waiting", 32'(line_o), 32'd1);
        check(sym_total - base == 1, "R9 one code out", 32'(sym_total - base), 32'd1);
        check(in_ready == 1'b0, "R7 busy while stalled", 32'(in_ready), 32'd0);
        take_word();
        wait_valid(ok);
        check(ok && out_data == 32'h0F0F_3C3C, "R9 second word after take",
              out_data, 32'h0F0F_3C3C);
        take_word();
        wait_ready(ok);

        // Multi-hot injection between words
        @(negedge clk);
        inj_en  = 1'b1;
        inj_val = 4'b0101;
        repeat (20) @(negedge clk);
        check(err == 1'b1, "R10 err set", 32'(err), 32'd1);
        check(ack_o == 1'b0, "R10 no ack", 32'(ack_o), 32'd0);
        check(out_valid == 1'b0, "R10 no word", 32'(out_valid), 32'd0);
        inj_en = 1'b0;
        repeat (20) @(negedge clk);
        check(err == 1'b1, "R10 err sticky", 32'(err), 32'd1);
        send_word(32'h7654_3210);
        wait_valid(ok);
        check(ok && out_data == 32'h7654_3210, "R10 no capture", out_data, 32'h7654_3210);
        take_word();
        wait_ready(ok);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(err == 1'b0, "R1 err cleared by reset", 32'(err), 32'd0);

        // Four-phase ordering and one-hot codes seen at the wires
        check(hs_viol == 0, "R4 R5 handshake order", 32'(hs_viol), 32'd0);
        check(hot_viol == 0, "R2 one hot lines", 32'(hot_viol), 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule